// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block carries out one elementary NAND flash operation at a time on behalf of a host. The host loads a command byte, an address byte, a buffer selection and two configuration words through a 16-bit register port. It then writes a single one-hot trigger bit to start a command cycle, an address cycle, a page transfer in either direction, an ID read or a status read. The sequencer drives the flash strobes and the 8-bit bus itself and moves page bytes between the flash and an on-chip buffer RAM. The buffer RAM sits outside the block behind a byte-wide port with one cycle of read latency.

When an operation finishes, a sticky completion flag is set. That flag drives a maskable interrupt and stays set until the host writes it to zero. Page transfers are held back by the flash ready/busy line. A soft reset bit aborts whatever is running and clears itself. Chip-enable outputs are decoded from an enable bit and a two-bit chip selection. Multi-byte flash addresses are built by the host from repeated single-byte address operations.

Top module: `nand_op_seq`

## Requirements
- R1: Register offsets on `host_addr` are 0 command, 1 address, 2 buffer select, 3 config A, 4 config B. After reset all five read 0, `irq` is 0, `fl_we_n`/`fl_re_n` are 1, `fl_cle`/`fl_ale` are 0 and every `fl_ce_n` line is 1.
- R2: A write to config B whose bits [5:0] hold exactly one set bit starts an operation. The bits are: bit 0 command, bit 1 address, bit 2 data-in (buffer to flash), bit 3 data-out (flash to buffer), bit 4 ID read, bit 5 status read. While the operation runs, its bit reads back as 1 in config B.
- R3: A config B write whose bits [5:0] are zero or have two or more set bits starts nothing, and no strobe pulses follow.
- R4: A trigger written while an operation is running is ignored. The running operation's bit keeps reading back, and no cycle of the ignored kind is issued.
- R5: Config B bit 15 is set when an operation completes and stays set until the host writes config B with bit 15 at 0. When completion falls in the same cycle as such a clearing write, the flag ends up set.
- R6: `irq` is 1 exactly when config B bit 15 is 1 and config A bit 4 (mask) is 0.
- R7: Writing 1 to config A bit 6 aborts any operation, returns the strobes to idle and clears config B. The bit then reads back as 1 for RST_CYC cycles, then clears itself. Triggers written meanwhile are ignored.
- R8: `fl_ce_n[k]` is 0 only when config A bit 7 is 1 and buffer-select bits [6:5] equal k.
- R9: A command operation issues one `fl_we_n` pulse with `fl_cle` high and `fl_io_out` equal to command register bits [7:0]. An address operation does the same with `fl_ale` high and address register bits [7:0]. Every strobe low phase lasts STROBE_CYC cycles.
- R10: Data-in sends PAGE_LEN bytes, one `fl_we_n` pulse each, read from buffer address {buffer-select[2:0], i} with i ascending from 0. It completes only after `fl_rb` is seen high.
- R11: Data-out waits for `fl_rb` high and issues no `fl_re_n` pulse before that. It then reads PAGE_LEN bytes, one `fl_re_n` pulse each, and writes byte i to buffer address {buffer-select[2:0], i}.
- R12: An ID read stores ID_LEN bytes and a status read stores 1 byte from buffer offset 0 upward, without waiting on `fl_rb`. Buffer bytes beyond that count are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| fl_cle | output | 1 | Flash command latch enable |
| fl_ale | output | 1 | Flash address latch enable |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_re_n | output | 1 | Flash read enable, active low |
| fl_ce_n | output | NUM_CE | Flash chip enables, active low |
| fl_io_out | output | 8 | Flash bus data driven out |
| fl_io_oe | output | 1 | Flash bus output enable |
| fl_io_in | input | 8 | Flash bus data driven in |
| fl_rb | input | 1 | Flash ready (1) / busy (0) |
| buf_addr | output | 3+log2(PAGE_LEN) | Buffer RAM byte address |
| buf_we | output | 1 | Buffer RAM write enable |
| buf_wdata | output | 8 | Buffer RAM write data |
| buf_rdata | input | 8 | Buffer RAM read data, one cycle after address |

## Verification
Two events can land on the same clock edge: an operation completing, and the host clearing the completion flag. The bench provokes this by parking a data-in transfer on a low ready/busy line. It raises ready/busy, then places a config B write of 0 exactly on the edge where completion is recorded, counting the ready synchroniser and the final state. The flag must read back set with the trigger bit gone. A plain clearing write on a quiet cycle must read back clear.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam logic [2:0] RA_CMD  = 3'd0;
    localparam logic [2:0] RA_ADDR = 3'd1;
    localparam logic [2:0] RA_BUF  = 3'd2;
    localparam logic [2:0] RA_CFGA = 3'd3;
    localparam logic [2:0] RA_CFGB = 3'd4;

    localparam int A_IRQ_MASK = 4;
    localparam int A_SOFT_RST = 6;
    localparam int A_CE_EN    = 7;
    localparam int B_DONE     = 15;
    localparam int TRIG_W     = 6;
    localparam int CS_LSB     = 5;

    typedef enum logic [2:0] {
        OP_CMD  = 3'd0,
        OP_ADDR = 3'd1,
        OP_DIN  = 3'd2,
        OP_DOUT = 3'd3,
        OP_ID   = 3'd4,
        OP_STAT = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_SETUP, ST_LOW, ST_HIGH, ST_WAITRB, ST_FIN
    } st_e;

    typedef struct packed {
        op_e        op;
        logic [2:0] buf_id;
        logic [7:0] byte_out;
    } job_t;

    function automatic logic single_hot(input logic [TRIG_W-1:0] v);
        return (v != '0) && ((v & (v - 6'd1)) == '0);
    endfunction

    function automatic op_e trig_op(input logic [TRIG_W-1:0] v);
        op_e o;
        o = OP_CMD;
        for (int i = TRIG_W - 1; i >= 0; i--) begin
            if (v[i]) o = op_e'(3'(i));
        end
        return o;
    endfunction

    function automatic logic op_reads(input op_e o);
        return (o == OP_DOUT) || (o == OP_ID) || (o == OP_STAT);
    endfunction

endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
    import nand_seq_pkg::*;
#(
    parameter int NUM_CE  = 4,
    parameter int RST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    input  logic              busy,
    input  logic              done_pulse,
    output logic              start,
    output job_t              job,
    output logic              soft_rst,
    output logic              irq,
    output logic [NUM_CE-1:0] ce_n
);
    localparam int CSW = (NUM_CE > 1) ? $clog2(NUM_CE) : 1;
    localparam int RCW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

    logic [15:0]       cmd_q, addr_q, cfga_q;
    logic [2:0]        buf_q;
    logic [CSW-1:0]    cs_q;
    logic              done_q;
    logic [TRIG_W-1:0] trig_q;
    logic [RCW-1:0]    rcnt;
    logic              wr_cfgb;
    op_e               new_op;

    assign wr_cfgb  = host_we && (host_addr == RA_CFGB);
    assign soft_rst = cfga_q[A_SOFT_RST];
    assign start    = wr_cfgb && single_hot(host_wdata[TRIG_W-1:0]) && !busy && !soft_rst;
    assign new_op   = trig_op(host_wdata[TRIG_W-1:0]);
    assign irq      = done_q && !cfga_q[A_IRQ_MASK];

    always_comb begin
        job.op       = new_op;
        job.buf_id   = buf_q;
        job.byte_out = (new_op == OP_ADDR) ? addr_q[7:0] : cmd_q[7:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            addr_q <= '0;
            cfga_q <= '0;
            buf_q  <= '0;
            cs_q   <= '0;
            done_q <= 1'b0;
            trig_q <= '0;
            rcnt   <= '0;
        end else begin
            if (host_we) begin
                case (host_addr)
                    RA_CMD:  cmd_q  <= host_wdata;
                    RA_ADDR: addr_q <= host_wdata;
                    RA_BUF: begin
                        buf_q <= host_wdata[2:0];
                        cs_q  <= host_wdata[CS_LSB +: CSW];
                    end
                    RA_CFGA: cfga_q <= host_wdata;
                    default: ;
                endcase
            end
            // the reset bit can be set by the host but only cleared here
            if (soft_rst) begin
                if (rcnt == RCW'(RST_CYC - 1)) begin
                    cfga_q[A_SOFT_RST] <= 1'b0;
                    rcnt               <= '0;
                end else begin
                    cfga_q[A_SOFT_RST] <= 1'b1;
                    rcnt               <= rcnt + RCW'(1);
                end
            end
            // completion has priority over a clearing write
            if (soft_rst)        done_q <= 1'b0;
            else if (done_pulse) done_q <= 1'b1;
            else if (wr_cfgb)    done_q <= done_q & host_wdata[B_DONE];

            if (soft_rst || done_pulse) trig_q <= '0;
            else if (start)             trig_q <= host_wdata[TRIG_W-1:0];
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            RA_CMD:  host_rdata = cmd_q;
            RA_ADDR: host_rdata = addr_q;
            RA_BUF: begin
                host_rdata[2:0]          = buf_q;
                host_rdata[CS_LSB +: CSW] = cs_q;
            end
            RA_CFGA: host_rdata = cfga_q;
            RA_CFGB: begin
                host_rdata[B_DONE]       = done_q;
                host_rdata[TRIG_W-1:0]   = trig_q;
            end
            default: host_rdata = '0;
        endcase
    end

    for (genvar k = 0; k < NUM_CE; k++) begin : g_ce
        assign ce_n[k] = !(cfga_q[A_CE_EN] && (cs_q == CSW'(k)));
    end

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done_q && !soft_rst && !(wr_cfgb && !host_wdata[B_DONE])) |=> done_q); // R5
    AST_SRST_DONE: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !done_q); // R7
    AST_CE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $countones(~ce_n) <= 1); // R8

endmodule

// File: rtl/nand_seq_core.sv
module nand_seq_core
    import nand_seq_pkg::*;
#(
    parameter int PAGE_LEN   = 16,
    parameter int ID_LEN     = 4,
    parameter int STROBE_CYC = 2,
    localparam int IW        = $clog2(PAGE_LEN),
    localparam int MAW       = 3 + IW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           soft_rst,
    input  logic           start,
    input  job_t           job,
    input  logic           rb,
    input  logic [7:0]     io_in,
    input  logic [7:0]     mem_rdata,
    output logic           cle,
    output logic           ale,
    output logic           we_n,
    output logic           re_n,
    output logic [7:0]     io_out,
    output logic           io_oe,
    output logic [MAW-1:0] mem_addr,
    output logic           mem_we,
    output logic [7:0]     mem_wdata,
    output logic           busy,
    output logic           done_pulse
);
    localparam int TW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;

    st_e           st;
    job_t          job_q;
    logic [IW-1:0] idx;
    logic [TW-1:0] tcnt;
    logic          rb_q;
    logic          tend, is_rd, active, last_byte;

    function automatic logic [IW-1:0] last_of(input op_e o);
        case (o)
            OP_DIN, OP_DOUT: return IW'(PAGE_LEN - 1);
            OP_ID:           return IW'(ID_LEN - 1);
            default:         return '0;
        endcase
    endfunction

    assign tend      = (tcnt == TW'(STROBE_CYC - 1));
    assign is_rd     = op_reads(job_q.op);
    assign active    = (st == ST_SETUP) || (st == ST_LOW) || (st == ST_HIGH);
    assign last_byte = (idx == last_of(job_q.op));

    always_ff @(posedge clk) begin
        if (rst) rb_q <= 1'b0;
        else     rb_q <= rb;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            st    <= ST_IDLE;
            job_q <= '0;
            idx   <= '0;
            tcnt  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    job_q <= job;
                    idx   <= '0;
                    tcnt  <= '0;
                    if (job.op == OP_DIN)       st <= ST_FETCH;
                    else if (job.op == OP_DOUT) st <= ST_WAITRB;
                    else                        st <= ST_SETUP;
                end
                ST_FETCH: begin
                    tcnt <= '0;
                    st   <= ST_SETUP;
                end
                ST_SETUP, ST_LOW: begin
                    if (tend) begin
                        tcnt <= '0;
                        st   <= (st == ST_SETUP) ? ST_LOW : ST_HIGH;
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                ST_HIGH: begin
                    if (tend) begin
                        tcnt <= '0;
                        if (last_byte) begin
                            st <= (job_q.op == OP_DIN) ? ST_WAITRB : ST_FIN;
                        end else begin
                            idx <= idx + IW'(1);
                            st  <= (job_q.op == OP_DIN) ? ST_FETCH : ST_SETUP;
                        end
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                ST_WAITRB: if (rb_q) begin
                    tcnt <= '0;
                    st   <= (job_q.op == OP_DOUT) ? ST_SETUP : ST_FIN;
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cle        = active && (job_q.op == OP_CMD);
    assign ale        = active && (job_q.op == OP_ADDR);
    assign we_n       = !((st == ST_LOW) && !is_rd);
    assign re_n       = !((st == ST_LOW) && is_rd);
    assign io_oe      = !is_rd && (active || (st == ST_FETCH));
    assign io_out     = (job_q.op == OP_DIN) ? mem_rdata : job_q.byte_out;
    assign mem_addr   = {job_q.buf_id, idx};
    assign mem_we     = (st == ST_LOW) && is_rd && tend;
    assign mem_wdata  = io_in;
    assign busy       = (st != ST_IDLE);
    assign done_pulse = (st == ST_FIN);

    logic [15:0] low_run;
    always_ff @(posedge clk) begin
        if (rst)                low_run <= '0;
        else if (!we_n || !re_n) low_run <= low_run + 16'd1;
        else                    low_run <= '0;
    end

    AST_JOB_STABLE: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && !soft_rst) |=> $stable(job_q)); // R4
    AST_RB_GATE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FIN && job_q.op == OP_DIN) |-> $past(rb_q)); // R10
    AST_SRST_IDLE: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !busy); // R7
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        ($rose(we_n) || $rose(re_n)) |-> (low_run == 16'(STROBE_CYC))); // R9

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
    import nand_seq_pkg::*;
#(
    parameter int PAGE_LEN   = 16,
    parameter int ID_LEN     = 4,
    parameter int STROBE_CYC = 2,
    parameter int RST_CYC    = 4,
    parameter int NUM_CE     = 4,
    localparam int MAW       = 3 + $clog2(PAGE_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              irq,
    output logic              fl_cle,
    output logic              fl_ale,
    output logic              fl_we_n,
    output logic              fl_re_n,
    output logic [NUM_CE-1:0] fl_ce_n,
    output logic [7:0]        fl_io_out,
    output logic              fl_io_oe,
    input  logic [7:0]        fl_io_in,
    input  logic              fl_rb,
    output logic [MAW-1:0]    buf_addr,
    output logic              buf_we,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata
);
    logic busy, done_pulse, start, soft_rst;
    job_t job;

    nand_seq_regs #(.NUM_CE(NUM_CE), .RST_CYC(RST_CYC)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .done_pulse (done_pulse),
        .start      (start),
        .job        (job),
        .soft_rst   (soft_rst),
        .irq        (irq),
        .ce_n       (fl_ce_n)
    );

    nand_seq_core #(.PAGE_LEN(PAGE_LEN), .ID_LEN(ID_LEN), .STROBE_CYC(STROBE_CYC)) u_core (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .start      (start),
        .job        (job),
        .rb         (fl_rb),
        .io_in      (fl_io_in),
        .mem_rdata  (buf_rdata),
        .cle        (fl_cle),
        .ale        (fl_ale),
        .we_n       (fl_we_n),
        .re_n       (fl_re_n),
        .io_out     (fl_io_out),
        .io_oe      (fl_io_oe),
        .mem_addr   (buf_addr),
        .mem_we     (buf_we),
        .mem_wdata  (buf_wdata),
        .busy       (busy),
        .done_pulse (done_pulse)
    );

endmodule

// File: tb/tb_nand_op_seq.sv
module tb_nand_op_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE = 16;
    localparam int IDL  = 4;
    localparam int SC   = 2;
    localparam int RC   = 4;
    localparam int NCE  = 4;
    localparam int MAW  = 3 + $clog2(PAGE);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic           host_we = 1'b0;
    logic [2:0]     host_addr = '0;
    logic [15:0]    host_wdata = '0;
    logic [15:0]    host_rdata;
    logic           irq, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_io_oe, buf_we;
    logic [NCE-1:0] fl_ce_n;
    logic [7:0]     fl_io_out, buf_wdata;
    logic [7:0]     fl_io_in = '0;
    logic           fl_rb = 1'b1;
    logic [MAW-1:0] buf_addr;
    logic [7:0]     buf_rdata = '0;

    nand_op_seq #(.PAGE_LEN(PAGE), .ID_LEN(IDL), .STROBE_CYC(SC), .RST_CYC(RC), .NUM_CE(NCE)) dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
        .fl_ce_n(fl_ce_n), .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe),
        .fl_io_in(fl_io_in), .fl_rb(fl_rb), .buf_addr(buf_addr), .buf_we(buf_we),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    // buffer RAM model
    logic [7:0] mem [0:8*PAGE-1];
    always @(posedge clk) begin
        if (buf_we) mem[buf_addr] <= buf_wdata;
        buf_rdata <= mem[buf_addr];
    end

    // flash model: reads return a computed pattern, writes are logged
    logic [7:0] salt = '0;
    int rd_k = 0;
    function automatic logic [7:0] fbyte(int k, logic [7:0] s);
        return 8'(k * 29 + 7) ^ s;
    endfunction
    always @(negedge fl_re_n) begin
        fl_io_in = fbyte(rd_k, salt);
        rd_k = rd_k + 1;
    end

    logic [9:0] flog [0:63];
    int  log_n = 0;
    time t_fall = 0;
    time last_w = 0;
    always @(negedge fl_we_n) t_fall = $time;
    always @(posedge fl_we_n) if (!rst) begin
        flog[log_n % 64] = {fl_cle, fl_ale, fl_io_out};
        log_n = log_n + 1;
        last_w = $time - t_fall;
    end

    int nchk = 0, nfail = 0, cyc = 0;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000) begin
            nchk = nchk + 1;
            nfail = nfail + 1;
            $display("FAIL watchdog (all requirements) act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rdreg(input logic [2:0] a, output logic [15:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_done();
        logic [15:0] d;
        for (int i = 0; i < 3000; i++) begin
            rdreg(3'd4, d);
            if (d[15]) break;
            @(negedge clk);
        end
    endtask

    task automatic ncyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [15:0] d;
        int n0, b;
        logic [7:0] v;
        void'($urandom(32'h1bad_5eed));
        for (int i = 0; i < 8*PAGE; i++) mem[i] = '0;
        ncyc(3);
        rst = 1'b0;
        ncyc(1);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rdreg(3'(a), d);
            chk("R1 reg reset", 32'(d), 32'h0);
        end
        chk("R1 strobes idle", {28'h0, fl_we_n, fl_re_n, fl_cle, fl_ale}, 32'hC);
        chk("R1 ce idle", 32'(fl_ce_n), 32'hF);
        chk("R1 irq idle", 32'(irq), 32'h0);

        // R8 chip enable decode
        for (int k = 0; k < NCE; k++) begin
            wr(3'd2, 16'(k << 5));
            wr(3'd3, 16'h0080);
            chk("R8 ce select", 32'(fl_ce_n), 32'(4'hF & ~(4'h1 << k)));
        end
        wr(3'd3, 16'h0000);
        chk("R8 ce disabled", 32'(fl_ce_n), 32'hF);

        // R9 command/address cycles, random bytes; R2 readback; R6 irq
        for (int it = 0; it < 20; it++) begin
            v = 8'($urandom);
            n0 = log_n;
            if (it % 2 == 0) begin
                wr(3'd0, {8'($urandom), v});
                wr(3'd4, 16'h0001);
                if (it == 0) begin
                    rdreg(3'd4, d);
                    chk("R2 trigger readback", 32'(d), 32'h0001);
                end
            end else begin
                wr(3'd1, {8'($urandom), v});
                wr(3'd4, 16'h0002);
            end
            wait_done();
            chk("R9 one pulse", 32'(log_n - n0), 32'd1);
            chk("R9 latch and byte", 32'(flog[n0 % 64]),
                32'({(it % 2 == 0) ? 2'b10 : 2'b01, v}));
            chk("R9 low width", 32'(last_w), 32'(SC * CLK_PERIOD));
            if (it == 0) begin
                chk("R6 irq unmasked", 32'(irq), 32'h1);
                wr(3'd3, 16'h0010);
                chk("R6 irq masked", 32'(irq), 32'h0);
                wr(3'd3, 16'h0000);
                wr(3'd4, 16'h8000);
                rdreg(3'd4, d);
                chk("R5 write of 1 keeps flag", 32'(d), 32'h8000);
            end
            wr(3'd4, 16'h0000);
            rdreg(3'd4, d);
            chk("R5 flag cleared", 32'(d), 32'h0);
        end

        // R3 invalid trigger patterns
        n0 = log_n;
        wr(3'd4, 16'h0003);
        rdreg(3'd4, d);
        chk("R3 two bits no start", 32'(d), 32'h0);
        wr(3'd4, 16'h0030);
        wr(3'd4, 16'h0000);
        ncyc(30);
        rdreg(3'd4, d);
        chk("R3 nothing ran", 32'(d), 32'h0);
        chk("R3 no strobes", 32'(log_n - n0), 32'd0);

        // R10 data-in for several buffers
        for (int it = 0; it < 3; it++) begin
            b = (it * 3 + 1) % 8;
            for (int i = 0; i < PAGE; i++) mem[b*PAGE + i] <= 8'($urandom);
            wr(3'd2, 16'(b));
            n0 = log_n;
            wr(3'd4, 16'h0004);
            wait_done();
            chk("R10 byte count", 32'(log_n - n0), 32'(PAGE));
            for (int i = 0; i < PAGE; i++)
                chk("R10 page byte", 32'(flog[(n0 + i) % 64]), 32'({2'b00, mem[b*PAGE + i]}));
            wr(3'd4, 16'h0000);
        end

        // R4 ignored trigger while data-in waits on busy flash; R5 collision
        fl_rb = 1'b0;
        wr(3'd2, 16'd5);
        wr(3'd4, 16'h0004);
        ncyc(200);
        n0 = log_n;
        wr(3'd4, 16'h0001);
        ncyc(20);
        rdreg(3'd4, d);
        chk("R4 running bit kept", 32'(d), 32'h0004);
        chk("R4 no command cycle", 32'(log_n - n0), 32'd0);
        chk("R10 waits on busy", 32'(d[15]), 32'h0);
        @(negedge clk); fl_rb = 1'b1;
        @(negedge clk);
        @(negedge clk);
        host_addr = 3'd4; host_wdata = 16'h0000; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        rdreg(3'd4, d);
        chk("R5 completion beats clear", 32'(d), 32'h8000);
        wr(3'd4, 16'h0000);

        // R11 data-out
        fl_rb = 1'b0;
        rd_k = 0; salt = 8'h5A;
        wr(3'd2, 16'd6);
        wr(3'd4, 16'h0008);
        ncyc(50);
        chk("R11 no read before ready", 32'(rd_k), 32'd0);
        fl_rb = 1'b1;
        wait_done();
        for (int i = 0; i < PAGE; i++)
            chk("R11 page byte", 32'(mem[6*PAGE + i]), 32'(fbyte(i, 8'h5A)));
        wr(3'd4, 16'h0000);

        // R12 ID and status reads
        for (int i = 0; i < PAGE; i++) mem[2*PAGE + i] <= 8'hEE;
        wr(3'd2, 16'd2);
        rd_k = 0; salt = 8'h11;
        fl_rb = 1'b0;
        wr(3'd4, 16'h0010);
        wait_done();
        for (int i = 0; i < IDL; i++)
            chk("R12 id byte", 32'(mem[2*PAGE + i]), 32'(fbyte(i, 8'h11)));
        chk("R12 id length", 32'(mem[2*PAGE + IDL]), 32'h00EE);
        wr(3'd4, 16'h0000);
        rd_k = 0; salt = 8'hC3;
        wr(3'd4, 16'h0020);
        wait_done();
        chk("R12 status byte", 32'(mem[2*PAGE]), 32'(fbyte(0, 8'hC3)));
        chk("R12 status length", 32'(mem[2*PAGE + 1]), 32'(fbyte(1, 8'h11)));
        wr(3'd4, 16'h0000);

        // R7 soft reset aborts a parked data-out
        fl_rb = 1'b0;
        rd_k = 0;
        wr(3'd4, 16'h0008);
        ncyc(10);
        n0 = log_n;
        wr(3'd3, 16'h0040);
        wr(3'd4, 16'h0001);
        rdreg(3'd3, d);
        chk("R7 reset bit held", 32'(d[6]), 32'h1);
        rdreg(3'd4, d);
        chk("R7 trigger cleared", 32'(d), 32'h0);
        ncyc(RC + 2);
        rdreg(3'd3, d);
        chk("R7 reset bit self-clears", 32'(d[6]), 32'h0);
        chk("R7 strobes idle", {30'h0, fl_we_n, fl_re_n}, 32'h3);
        chk("R7 trigger during reset ignored", 32'(log_n - n0), 32'd0);
        fl_rb = 1'b1;
        ncyc(20);
        chk("R7 aborted op stays idle", 32'(rd_k), 32'd0);
        wr(3'd0, 16'h00A5);
        n0 = log_n;
        wr(3'd4, 16'h0001);
        wait_done();
        chk("R7 new op after reset", 32'(flog[n0 % 64]), 32'h2A5);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule